// File: doc/BRIEF.md
# Programmable-Priority Bus Arbiter

This block decides which of several masters drives a shared on-chip system bus. Each master has a small priority value that software can rewrite at any time. Whenever the bus is free, the arbiter picks the requesting master with the numerically largest value. If several requesting masters share that value, the one with the lowest index wins. The decision is registered. It produces a one-hot grant vector and the binary index of the winner.

While the slave side reports a transfer in progress (`xfer_busy` high), the current grant is frozen. A higher-ranked request therefore never cuts into a running transfer. When `xfer_busy` is low, the arbiter re-decides on every clock edge. Priorities are written as one packed word. The field for master i occupies bits [3i+2:3i] with the default width, so master 0 sits in the least significant bits. The word reads back unchanged. The arbiter does no address decoding, abort reporting or byte-lane handling; the bus is little-endian only.

Top module: `prio_bus_arbiter`

## Requirements
- R1: After reset, every priority field is 0, `cfg_rdata` reads 0, `bus_grant` is all-zero and `grant_idx` is 0.
- R2: At a decision edge, the grant goes to the requesting master whose priority field is numerically largest (7 is the highest with 3-bit fields).
- R3: When several requesting masters share the largest field value, the lowest-indexed of them is granted (order 0, 1, 2, 3).
- R4: If no request is asserted at a decision edge, `bus_grant` becomes all-zero.
- R5: While `xfer_busy` is high and a grant is active, `bus_grant` and `grant_idx` hold their values, regardless of new or higher-priority requests.
- R6: `bus_grant` is one-hot or all-zero and changes only on a clock edge. When it is non-zero, `grant_idx` is the index of its set bit.
- R7: A write with `cfg_we` high stores `cfg_wdata` at the clock edge, with master i's field at bits [PRIO_W*i+PRIO_W-1 : PRIO_W*i]. `cfg_rdata` returns the stored word from the next cycle on.
- R8: A priority write made during a busy transfer does not alter the grant in progress. The new values are used at the first decision after `xfer_busy` falls.
- R9: A decision is taken on every edge where `xfer_busy` is low or no grant is active. A master holding the grant with `xfer_busy` low loses it to a better-ranked requester at the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req | input | NUM_MASTERS | One bus request per master |
| xfer_busy | input | 1 | High while the granted transfer is in progress |
| cfg_we | input | 1 | Priority word write enable |
| cfg_wdata | input | NUM_MASTERS*PRIO_W | Packed priority fields to write, master 0 lowest |
| cfg_rdata | output | NUM_MASTERS*PRIO_W | Packed priority fields currently stored |
| bus_grant | output | NUM_MASTERS | Registered one-hot grant, all-zero when idle |
| grant_idx | output | $clog2(NUM_MASTERS) | Index of the granted master |

## Verification
The bench builds the block with its defaults: four masters and 3-bit priority fields. This gives a 12-bit priority word, so every field value from 0 to 7 and every 4-bit request pattern can be reached. The vector table covers pure index order, one clear winner, ties at mid-level and at the top level, and the empty request set. The directed part holds a grant under `xfer_busy` while a stronger master requests and the priorities are rewritten. It then shows the rewritten order taking over once the bus goes idle.

// File: rtl/arb_pkg.sv
package arb_pkg;
   // Width of a master index for a given master count (at least one bit).
   function automatic int idx_width(input int masters);
      return (masters > 1) ? $clog2(masters) : 1;
   endfunction
endpackage

// File: rtl/arb_prio_regs.sv
module arb_prio_regs #(
   parameter int NUM_MASTERS = 4,
   parameter int PRIO_W      = 3
) (
   input  logic                               clk,
   input  logic                               rst_n,
   input  logic                               cfg_we,
   input  logic [NUM_MASTERS*PRIO_W-1:0]      cfg_wdata,
   output logic [NUM_MASTERS-1:0][PRIO_W-1:0] prio
);
   localparam int WORD_W = NUM_MASTERS * PRIO_W;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         prio <= '0;
      else if (cfg_we)
         prio <= cfg_wdata;
   end

   AST_CFG_STORE: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_we |=> (WORD_W'(prio) == $past(cfg_wdata)));  // R7
   AST_CFG_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_we |=> $stable(prio));  // R7
endmodule

// File: rtl/arb_prio_select.sv
module arb_prio_select #(
   parameter int NUM_MASTERS = 4,
   parameter int PRIO_W      = 3
) (
   input  logic [NUM_MASTERS-1:0]             req,
   input  logic [NUM_MASTERS-1:0][PRIO_W-1:0] prio,
   output logic [NUM_MASTERS-1:0]             win_onehot,
   output logic [arb_pkg::idx_width(NUM_MASTERS)-1:0] win_idx
);
   localparam int IDX_W = arb_pkg::idx_width(NUM_MASTERS);

   // beaten[i][j]: master j rules master i out.
   logic [NUM_MASTERS-1:0][NUM_MASTERS-1:0] beaten;

   for (genvar i = 0; i < NUM_MASTERS; i++) begin : g_cand
      for (genvar j = 0; j < NUM_MASTERS; j++) begin : g_rival
         if (j < i) begin : g_lower
            assign beaten[i][j] = req[j] && (prio[j] >= prio[i]);
         end else if (j > i) begin : g_higher
            assign beaten[i][j] = req[j] && (prio[j] > prio[i]);
         end else begin : g_self
            assign beaten[i][j] = 1'b0;
         end
      end
      assign win_onehot[i] = req[i] && (beaten[i] == '0);
   end

   always_comb begin
      win_idx = '0;
      for (int k = 0; k < NUM_MASTERS; k++)
         if (win_onehot[k]) win_idx = IDX_W'(k);
   end
endmodule

// File: rtl/prio_bus_arbiter.sv
module prio_bus_arbiter #(
   parameter int NUM_MASTERS = 4,
   parameter int PRIO_W      = 3
) (
   input  logic                                       clk,
   input  logic                                       rst_n,
   input  logic [NUM_MASTERS-1:0]                     req,
   input  logic                                       xfer_busy,
   input  logic                                       cfg_we,
   input  logic [NUM_MASTERS*PRIO_W-1:0]              cfg_wdata,
   output logic [NUM_MASTERS*PRIO_W-1:0]              cfg_rdata,
   output logic [NUM_MASTERS-1:0]                     bus_grant,
   output logic [arb_pkg::idx_width(NUM_MASTERS)-1:0] grant_idx
);
   localparam int IDX_W  = arb_pkg::idx_width(NUM_MASTERS);
   localparam int WORD_W = NUM_MASTERS * PRIO_W;

   if (NUM_MASTERS < 2) begin : g_bad_masters
      $error("prio_bus_arbiter: NUM_MASTERS must be at least 2");
   end
   if (PRIO_W < 1 || PRIO_W > 8) begin : g_bad_prio
      $error("prio_bus_arbiter: PRIO_W must lie in 1..8");
   end

   logic [NUM_MASTERS-1:0][PRIO_W-1:0] prio;
   logic [NUM_MASTERS-1:0]             win_onehot;
   logic [IDX_W-1:0]                   win_idx;
   logic                               decide;

   arb_prio_regs #(.NUM_MASTERS(NUM_MASTERS), .PRIO_W(PRIO_W)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_we    (cfg_we),
      .cfg_wdata (cfg_wdata),
      .prio      (prio)
   );

   arb_prio_select #(.NUM_MASTERS(NUM_MASTERS), .PRIO_W(PRIO_W)) u_sel (
      .req        (req),
      .prio       (prio),
      .win_onehot (win_onehot),
      .win_idx    (win_idx)
   );

   assign cfg_rdata = WORD_W'(prio);
   assign decide    = !xfer_busy || (bus_grant == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bus_grant <= '0;
         grant_idx <= '0;
      end else if (decide) begin
         bus_grant <= win_onehot;
         grant_idx <= win_idx;
      end
   end

   AST_GRANT_ONEHOT0: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(bus_grant));  // R6
   AST_IDX_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_grant != '0) |-> bus_grant[grant_idx]);  // R6
   AST_HOLD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_busy && bus_grant != '0) |=> ($stable(bus_grant) && $stable(grant_idx)));  // R5
   AST_IDLE_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      (!xfer_busy && req == '0) |=> (bus_grant == '0));  // R4

   for (genvar i = 0; i < NUM_MASTERS; i++) begin : g_rule_chk
      AST_WIN_RULE: assert property (@(posedge clk) disable iff (!rst_n)
         (decide && req[i]) |=> ((bus_grant != '0) &&
            (($past(prio[i]) < $past(prio[win_idx])) ||
             (($past(prio[i]) == $past(prio[win_idx])) && (i >= grant_idx)))));  // R2 R3
   end
endmodule

// File: tb/tb_prio_bus_arbiter.sv
module tb_prio_bus_arbiter;
   localparam int NM = 4;
   localparam int PW = 3;
   localparam int WW = NM * PW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NM-1:0] req = '0;
   logic          xfer_busy = 1'b0;
   logic          cfg_we = 1'b0;
   logic [WW-1:0] cfg_wdata = '0;
   logic [WW-1:0] cfg_rdata;
   logic [NM-1:0] bus_grant;
   logic [1:0]    grant_idx;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   always #2.5 clk = ~clk;  // 200 MHz

   prio_bus_arbiter #(.NUM_MASTERS(NM), .PRIO_W(PW)) dut (
      .clk(clk), .rst_n(rst_n), .req(req), .xfer_busy(xfer_busy),
      .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
      .bus_grant(bus_grant), .grant_idx(grant_idx)
   );

   // {priority word, request, expected grant}; field i at bits [3i+2:3i]
   localparam logic [19:0] VEC [8] = '{
      {12'h000, 4'b1111, 4'b0001},  // R3 all zero: index order
      {12'hE00, 4'b1111, 4'b1000},  // R2 master 3 at 7
      {12'h168, 4'b0110, 4'b0010},  // R3 tie at 5
      {12'h168, 4'b1101, 4'b0100},  // R2 master 2 alone at 5
      {12'h65A, 4'b1111, 4'b0010},  // R3 masters 1,3 tie at 3
      {12'h65A, 4'b1001, 4'b1000},  // R2 3 beats 2
      {12'h65A, 4'b0000, 4'b0000},  // R4 no request
      {12'hFFF, 4'b1100, 4'b0100}   // R3 tie at the top level
   };

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   function automatic logic [1:0] idx_of(input logic [3:0] g);
      for (int k = 0; k < 4; k++) if (g[k]) return 2'(k);
      return 2'd0;
   endfunction

   initial begin
      #(200000 * 5);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog expired");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R1 grant after reset", 32'(bus_grant), 32'h0);
      check("R1 idx after reset", 32'(grant_idx), 32'h0);
      check("R1 prio after reset", 32'(cfg_rdata), 32'h0);
      rst_n = 1'b1;
      tick();

      for (int v = 0; v < 8; v++) begin
         cfg_we = 1'b1; cfg_wdata = VEC[v][19:8]; req = '0;
         tick();
         cfg_we = 1'b0;
         check("R7 readback", 32'(cfg_rdata), 32'(VEC[v][19:8]));
         req = VEC[v][7:4];
         tick();
         check("R2/R3/R4 vector grant", 32'(bus_grant), 32'(VEC[v][3:0]));
         if (VEC[v][3:0] != '0)
            check("R6 idx matches grant", 32'(grant_idx), 32'(idx_of(VEC[v][3:0])));
      end

      // Directed: hold under busy, write during busy (R5, R8), re-arbitration (R9)
      req = '0; cfg_we = 1'b1; cfg_wdata = 12'h000;
      tick();
      cfg_we = 1'b0; req = 4'b0100;
      tick();
      check("R2 single request granted", 32'(bus_grant), 32'h4);
      xfer_busy = 1'b1; req = 4'b0111;
      tick();
      check("R5 held while busy", 32'(bus_grant), 32'h4);
      check("R5 idx held while busy", 32'(grant_idx), 32'h2);
      cfg_we = 1'b1; cfg_wdata = 12'h00F;  // master 0 -> 7, master 1 -> 1
      tick();
      cfg_we = 1'b0;
      check("R8 write during busy keeps grant", 32'(bus_grant), 32'h4);
      check("R7 write during busy stored", 32'(cfg_rdata), 32'h00F);
      req = 4'b0000;
      tick();
      check("R5 held with requests dropped", 32'(bus_grant), 32'h4);
      req = 4'b0110; xfer_busy = 1'b0;
      tick();
      check("R8 new priority used after busy", 32'(bus_grant), 32'h2);
      req = 4'b0111;
      tick();
      check("R9 idle holder loses to higher", 32'(bus_grant), 32'h1);
      check("R6 idx zero for master 0", 32'(grant_idx), 32'h0);
      req = 4'b0000;
      tick();
      check("R4 idle no request clears", 32'(bus_grant), 32'h0);

      // Reset mid-operation restores defaults (R1)
      req = 4'b1000;
      tick();
      rst_n = 1'b0;
      #1;
      check("R1 async reset grant", 32'(bus_grant), 32'h0);
      check("R1 async reset prio", 32'(cfg_rdata), 32'h0);
      @(negedge clk);
      rst_n = 1'b1;
      req = 4'b1010;
      tick();
      check("R3 index order after reset", 32'(bus_grant), 32'h2);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end
endmodule